// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps three bitmaps over a vector space of 256 entries: pending requests, vectors in service, and the trigger mode of each request. Requests arrive with a vector and a level flag. The block works out a processor priority from a software-written task priority and the most recently accepted in-service vector. It then offers the highest pending vector to the core, but only when that vector's 16-vector class is above the priority class.

The core takes the offered vector with an accept strobe and retires the highest in-service vector with an end-of-interrupt strobe. Requests for vectors in class 0 are refused and latched as an error. A commit strobe moves the accumulated error bits into a readable error register. While the software-enable input is low, every request is discarded.

A small stack holds the vectors in service, and its top drives the priority. Pushing onto a full stack sets a sticky overflow flag.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset, pend_o is 0, ppr_o is 0x00, err_o is 0x00 and isr_ovf_o is 0. The request, in-service and trigger bitmaps are all clear.
- R2: A request with sw_en_i high and a vector of 16 or more sets that vector's pending bit. The result is visible on the outputs in the cycle after the request.
- R3: A request with sw_en_i high and a vector below 16 records nothing in the pending bitmap. It sets bit 6 (the receive-illegal-vector bit, value 0x40) of the pending error state.
- R4: While sw_en_i is low, every request is dropped, including a request for an illegal vector. Such a request changes neither the pending bitmap nor the pending error state.
- R5: pend_o is high only when the highest set pending vector has a class (vector bits 7:4) strictly greater than the class of ppr_o. pend_vec_o then carries that vector. A pending vector whose class equals the priority class is not offered.
- R6: ppr_o equals the task priority when the task priority class is at least the class of the top in-service stack entry. Otherwise ppr_o is that entry with bits 3:0 cleared. The entry of an empty stack is 0.
- R7: When ack_i is high while pend_o is high and eoi_i is low, the offered vector leaves the pending bitmap, enters the in-service bitmap and is pushed on the stack. An ack_i with pend_o low, or in the same cycle as eoi_i, is ignored.
- R8: eoi_i clears the highest set in-service bit and pops the stack. When no in-service bit is set, eoi_i has no effect.
- R9: err_commit_i copies the pending error bits into err_o and clears the pending bits.
- R10: Latching a request also records req_level_i as that vector's trigger mode. pend_level_o shows the trigger mode of the offered vector.
- R11: An accept while the stack already holds STK_DEPTH entries does not push. It sets isr_ovf_o, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_en_i | input | 1 | Software enable; requests are dropped when low |
| req_valid_i | input | 1 | Interrupt request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | Request is level triggered |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_i | input | 8 | Task priority value |
| ack_i | input | 1 | Core accepts the offered vector |
| eoi_i | input | 1 | End of interrupt |
| err_commit_i | input | 1 | Move pending error bits into err_o |
| pend_o | output | 1 | A deliverable vector is offered |
| pend_vec_o | output | 8 | Offered vector |
| pend_level_o | output | 1 | Trigger mode of the offered vector |
| ppr_o | output | 8 | Processor priority |
| err_o | output | 8 | Committed error status |
| isr_ovf_o | output | 1 | Sticky in-service stack overflow |

## Verification
The bench targets the boundary of the class comparison. A pending vector whose class equals the priority class must stay hidden; a design that compared with greater-or-equal would offer it early. The bench also checks that the task priority masks an in-service class only when it is the higher of the two, and that an EOI with nothing in service changes nothing; an unguarded pop would corrupt the priority. Illegal vectors must raise only the error bit and leave no pending bit, and a disabled controller must drop even those. An accept in the same cycle as an EOI must not be taken, and pushing onto a full stack must raise the sticky flag without changing the priority.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int unsigned CLS_LO     = 4;  // low bits below the priority class
  localparam int unsigned ERR_W      = 8;
  localparam int unsigned ERR_RX_ILL = 6;  // receive-illegal-vector error bit
endpackage

// File: rtl/vpc_msb_find.sv
module vpc_msb_find #(
  parameter int unsigned N = 256,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = W'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/vpc_isr_stack.sv
module vpc_isr_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned VW    = 8,
  localparam int unsigned SPW  = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [VW-1:0] push_val_i,
  output logic [VW-1:0] top_o,
  output logic          ovf_o
);
  logic [VW-1:0]  stk_q [DEPTH];
  logic [SPW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      ovf_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (pop_i) begin
      if (sp_q != '0) sp_q <= sp_q - 1'b1;
    end else if (push_i) begin
      if (sp_q == SPW'(DEPTH)) begin
        ovf_o <= 1'b1;
      end else begin
        stk_q[sp_q[$clog2(DEPTH)-1:0]] <= push_val_i;
        sp_q <= sp_q + 1'b1;
      end
    end
  end

  assign top_o = (sp_q == '0) ? '0 : stk_q[sp_q[$clog2(DEPTH)-1:0] - 1'b1];

  a_r11_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r11_sp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SPW'(DEPTH));
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int unsigned NVEC      = 256,
  parameter int unsigned STK_DEPTH = 16,
  localparam int unsigned VW       = $clog2(NVEC),
  localparam int unsigned MIN_VEC  = 1 << CLS_LO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_en_i,
  input  logic             req_valid_i,
  input  logic [VW-1:0]    req_vec_i,
  input  logic             req_level_i,
  input  logic             tpr_we_i,
  input  logic [VW-1:0]    tpr_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  input  logic             err_commit_i,
  output logic             pend_o,
  output logic [VW-1:0]    pend_vec_o,
  output logic             pend_level_o,
  output logic [VW-1:0]    ppr_o,
  output logic [ERR_W-1:0] err_o,
  output logic             isr_ovf_o
);
  logic [NVEC-1:0]  irr_q, isr_q, tmr_q;
  logic [VW-1:0]    tpr_q, irr_top, isr_top, stk_top;
  logic             irr_any, isr_any;
  logic [ERR_W-1:0] err_pend_q, err_new;
  logic             req_ok, req_ill, accept, eoi_do;

  vpc_msb_find #(.N(NVEC)) u_irr_find (.vec_i(irr_q), .idx_o(irr_top), .any_o(irr_any));
  vpc_msb_find #(.N(NVEC)) u_isr_find (.vec_i(isr_q), .idx_o(isr_top), .any_o(isr_any));

  assign accept = ack_i && pend_o && !eoi_i;
  assign eoi_do = eoi_i && isr_any;

  vpc_isr_stack #(.DEPTH(STK_DEPTH), .VW(VW)) u_stack (
    .clk_i, .rst_ni,
    .push_i(accept), .pop_i(eoi_do), .push_val_i(pend_vec_o),
    .top_o(stk_top), .ovf_o(isr_ovf_o)
  );

  // processor priority: task priority unless the in-service class is higher
  always_comb begin
    if (tpr_q[VW-1:CLS_LO] >= stk_top[VW-1:CLS_LO]) ppr_o = tpr_q;
    else ppr_o = {stk_top[VW-1:CLS_LO], {CLS_LO{1'b0}}};
  end

  assign pend_o       = irr_any && (irr_top[VW-1:CLS_LO] > ppr_o[VW-1:CLS_LO]);
  assign pend_vec_o   = irr_top;
  assign pend_level_o = tmr_q[irr_top];

  assign req_ok  = req_valid_i && sw_en_i && (req_vec_i >= VW'(MIN_VEC));
  assign req_ill = req_valid_i && sw_en_i && (req_vec_i <  VW'(MIN_VEC));

  always_comb begin
    err_new = '0;
    err_new[ERR_RX_ILL] = req_ill;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
      tpr_q <= '0;
    end else begin
      if (tpr_we_i) tpr_q <= tpr_i;
      if (accept) begin
        irr_q[pend_vec_o] <= 1'b0;
        isr_q[pend_vec_o] <= 1'b1;
      end
      if (eoi_do) isr_q[isr_top] <= 1'b0;
      if (req_ok) begin
        irr_q[req_vec_i] <= 1'b1;
        tmr_q[req_vec_i] <= req_level_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_pend_q <= '0;
      err_o      <= '0;
    end else if (err_commit_i) begin
      err_o      <= err_pend_q;
      err_pend_q <= err_new;
    end else begin
      err_pend_q <= err_pend_q | err_new;
    end
  end

  a_r2_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> irr_q[$past(req_vec_i)]);
  a_r10_tmr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> tmr_q[$past(req_vec_i)] == $past(req_level_i));
  a_r3_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && sw_en_i && req_vec_i < VW'(MIN_VEC))
      |=> err_pend_q[ERR_RX_ILL] && ((irr_q & ~$past(irr_q)) == '0));
  a_r4_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !sw_en_i && !err_commit_i)
      |=> ((irr_q & ~$past(irr_q)) == '0) && $stable(err_pend_q));
  a_r7_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_o && !eoi_i) |=> isr_q[$past(pend_vec_o)]);
  a_r8_eoi_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_q == '0) |=> isr_q == '0);
  a_r9_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_commit_i |=> err_o == $past(err_pend_q));
endmodule

// File: tb/sim_vec_prio_ctrl.sv
`timescale 1ns/1ps
module sim_vec_prio_ctrl;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       sw_en_i = 1'b1, req_valid_i = 1'b0, req_level_i = 1'b0;
  logic [7:0] req_vec_i = '0, tpr_i = '0;
  logic       tpr_we_i = 1'b0, ack_i = 1'b0, eoi_i = 1'b0, err_commit_i = 1'b0;
  logic       pend_o, pend_level_o, isr_ovf_o;
  logic [7:0] pend_vec_o, ppr_o, err_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_prio_ctrl #(.NVEC(256), .STK_DEPTH(4)) u0 (
    .clk_i(clk), .rst_ni, .sw_en_i, .req_valid_i, .req_vec_i, .req_level_i,
    .tpr_we_i, .tpr_i, .ack_i, .eoi_i, .err_commit_i,
    .pend_o, .pend_vec_o, .pend_level_o, .ppr_o, .err_o, .isr_ovf_o);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [7:0] v, input logic lvl);
    @(negedge clk); req_valid_i = 1'b1; req_vec_i = v; req_level_i = lvl;
    @(negedge clk); req_valid_i = 1'b0;
  endtask
  task automatic ack();
    @(negedge clk); ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
  endtask
  task automatic eoi();
    @(negedge clk); eoi_i = 1'b1; @(negedge clk); eoi_i = 1'b0;
  endtask
  task automatic ack_eoi();
    @(negedge clk); ack_i = 1'b1; eoi_i = 1'b1;
    @(negedge clk); ack_i = 1'b0; eoi_i = 1'b0;
  endtask
  task automatic set_tpr(input logic [7:0] v);
    @(negedge clk); tpr_we_i = 1'b1; tpr_i = v; @(negedge clk); tpr_we_i = 1'b0;
  endtask
  task automatic commit();
    @(negedge clk); err_commit_i = 1'b1; @(negedge clk); err_commit_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend_o, 0);
    chk("R1 ppr", ppr_o, 8'h00);
    chk("R1 err", err_o, 8'h00);
    chk("R1 ovf", isr_ovf_o, 0);
  endtask

  task automatic t_latch();
    req(8'h45, 1'b0);
    chk("R2 pend", pend_o, 1);
    chk("R2 vec", pend_vec_o, 8'h45);
    chk("R10 edge", pend_level_o, 0);
    req(8'h80, 1'b1);
    chk("R2 highest", pend_vec_o, 8'h80);
    chk("R10 level", pend_level_o, 1);
  endtask

  task automatic t_priority();
    ack();
    chk("R7 ppr after accept", ppr_o, 8'h80);
    chk("R5 lower class hidden", pend_o, 0);
    req(8'h85, 1'b0);
    chk("R5 equal class hidden", pend_o, 0);
    req(8'h90, 1'b0);
    chk("R5 higher offered", pend_o, 1);
    chk("R5 higher vec", pend_vec_o, 8'h90);
    set_tpr(8'hA3);
    chk("R6 tpr wins", ppr_o, 8'hA3);
    chk("R6 tpr masks", pend_o, 0);
    set_tpr(8'h00);
    chk("R6 isr class wins", ppr_o, 8'h80);
  endtask

  task automatic t_eoi();
    ack();
    chk("R7 nested ppr", ppr_o, 8'h90);
    eoi();
    chk("R8 pop ppr", ppr_o, 8'h80);
    chk("R8 equal still hidden", pend_o, 0);
    eoi();
    chk("R8 empty ppr", ppr_o, 8'h00);
    chk("R8 vec", pend_vec_o, 8'h85);
    eoi();
    chk("R8 no-op ppr", ppr_o, 8'h00);
    chk("R8 no-op pend", pend_vec_o, 8'h85);
    ack(); eoi();
    chk("R8 next vec", pend_vec_o, 8'h45);
    ack(); eoi();
    chk("R7 irr drained", pend_o, 0);
    ack();
    chk("R7 ack without pend", ppr_o, 8'h00);
    req(8'h70, 1'b0); ack();
    chk("R7 ppr 70", ppr_o, 8'h70);
    req(8'h90, 1'b0);
    ack_eoi();
    chk("R7 ack with eoi ignored ppr", ppr_o, 8'h00);
    chk("R7 ack with eoi ignored vec", pend_vec_o, 8'h90);
    ack();
    chk("R7 ppr 90", ppr_o, 8'h90);
    eoi();
    chk("R8 cleared", ppr_o, 8'h00);
  endtask

  task automatic t_error();
    req(8'h0F, 1'b0);
    chk("R3 not latched", pend_o, 0);
    chk("R9 err before commit", err_o, 8'h00);
    commit();
    chk("R9 err committed", err_o, 8'h40);
    commit();
    chk("R9 pending cleared", err_o, 8'h00);
  endtask

  task automatic t_disabled();
    @(negedge clk); sw_en_i = 1'b0;
    req(8'h50, 1'b0);
    chk("R4 request dropped", pend_o, 0);
    req(8'h05, 1'b0);
    commit();
    chk("R4 illegal dropped", err_o, 8'h00);
    @(negedge clk); sw_en_i = 1'b1;
  endtask

  task automatic t_overflow();
    for (int k = 2; k <= 5; k++) begin
      req(8'(k * 16), 1'b0);
      ack();
    end
    chk("R11 full no ovf", isr_ovf_o, 0);
    chk("R11 ppr top", ppr_o, 8'h50);
    req(8'h60, 1'b0);
    chk("R11 offered", pend_vec_o, 8'h60);
    ack();
    chk("R11 ovf set", isr_ovf_o, 1);
    chk("R11 push dropped", ppr_o, 8'h50);
    eoi();
    chk("R11 sticky", isr_ovf_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_priority();
    t_eoi();
    t_error();
    t_disabled();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule